// File: doc/BRIEF.md
# Reloading Longword DMA Channel

This block is one DMA channel that copies longwords from a source region to a destination region. On each transfer it reads the source address and writes the same word to the destination address. The source pointer then moves up by one word and the destination pointer moves down by one word. A transfer counter ends the job. Software programs the source start, the destination start, the transfer count and a control word through a small write port. A level-sensitive transfer request then starts the channel. Before it drives the memory port, the channel requests the bus and waits for the grant.

With reload switched on, the channel works in groups of four transfers. After each group the source pointer returns to its programmed start. The channel also drops its bus request and waits in idle until the transfer request is seen again. The destination pointer and the count keep moving across groups. With reload off, the channel holds the bus from the first transfer until the count runs out.

When the count reaches zero, the channel does three things:
- it sets a sticky done flag, which disables the channel;
- it pulses a clear strobe back to the requesting source;
- it raises a level interrupt if interrupts are enabled.

For reload to act as intended, the count should be a multiple of four.

Top module: `dmarl_top`

## Requirements
- R1: After reset, `breq`, `bus_valid`, `irq` and `req_clr` are low.
- R2: Each transfer is one read at the current source address, then one write of the returned data to the current destination address. Longword steps apply: the source advances by 4 and the destination falls by 4 after every transfer.
- R3: A job of N transfers makes exactly N read/write pairs. On the last write, `req_clr` pulses high for a single cycle and the bus request is dropped.
- R4: With reload on (control bit 1), the read address after every fourth transfer is the programmed source start again. The destination keeps falling by 4 across the group boundary.
- R5: With reload on, `breq` goes low after every group of four transfers. While `dreq` stays low, no new bus request and no bus cycle occur. The channel resumes from the reloaded source when `dreq` returns. With reload off, `breq` stays high for the whole job.
- R6: `irq` is high only after the count reaches zero with interrupt enable (control bit 2) set, never at a group boundary, and never when the enable is clear.
- R7: Reaching zero count sets the done flag (control bit 3). The channel then makes no bus request for any `dreq` until software writes the control word with bit 3 = 0 and bit 0 (enable) = 1. Writing bit 3 = 1 leaves the flag set.
- R8: The memory port follows valid/ready: once `bus_valid` is high, it stays high with `bus_addr`, `bus_write` and `bus_wdata` unchanged until a cycle with `bus_ready` high accepts it. A read returns its data on `bus_rdata` in that same cycle. `bus_ready` is the only back-pressure.
- R9: `bus_valid` is never high before `bgnt` has been granted. `breq` rises when the enabled channel sees `dreq`.
- R10: Register selects for `reg_sel` are 0 = source start, 1 = destination, 2 = count, 3 = control. A write with control bit 0 set restarts the four-transfer group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| dreq | input | 1 | Transfer request level |
| breq | output | 1 | Bus request |
| bgnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Memory cycle valid |
| bus_ready | input | 1 | Memory cycle accepted |
| bus_write | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | 32 | Memory address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ready on a read |
| irq | output | 1 | Transfer-end interrupt level |
| req_clr | output | 1 | One-cycle request-source clear strobe |

## Verification
The copy path is driven with jobs of one, five, eight and twelve transfers. Each job runs with reload on or off and with `bus_ready` held high, toggling, or high two cycles in three. Comparing the reload and non-reload jobs on the same addresses shows whether the source pointer wraps and whether the destination and count run on. The uneven ready patterns test the hold rules under back-pressure. The count of `breq` falling edges separates bus release per group from release only at the end. A job whose `dreq` is dropped at a group boundary shows that the channel really waits and then continues from the reloaded source. A final sequence tests the sticky done flag and re-enabling.

// File: rtl/dmarl_pkg.sv
package dmarl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR} dmarl_st_e;
  localparam int SEL_SRC = 0;
  localparam int SEL_DST = 1;
  localparam int SEL_CNT = 2;
  localparam int SEL_CTL = 3;
  localparam int CB_EN   = 0;
  localparam int CB_RL   = 1;
  localparam int CB_IE   = 2;
  localparam int CB_DONE = 3;
endpackage

// File: rtl/dmarl_ctl.sv
module dmarl_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [3:0] ctl_wdata,
  input  logic       done_set,
  output logic       active,
  output logic       rl,
  output logic       irq,
  output logic       grp_clr
);
  import dmarl_pkg::*;

  logic en_q, rl_q, ie_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      rl_q   <= 1'b0;
      ie_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (ctl_we) begin
        en_q <= ctl_wdata[CB_EN];
        rl_q <= ctl_wdata[CB_RL];
        ie_q <= ctl_wdata[CB_IE];
      end
      if (done_set)
        done_q <= 1'b1;
      else if (ctl_we)
        done_q <= done_q & ctl_wdata[CB_DONE];
    end
  end

  assign active  = en_q & ~done_q;
  assign rl      = rl_q;
  assign irq     = done_q & ie_q;
  assign grp_clr = ctl_we & ctl_wdata[CB_EN];

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !ctl_we) |=> done_q);
endmodule

// File: rtl/dmarl_dp.sv
module dmarl_dp #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int STEP   = 4,
  parameter int GRP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_src,
  input  logic              wr_dst,
  input  logic              wr_cnt,
  input  logic [ADDR_W-1:0] wdata_a,
  input  logic [CNT_W-1:0]  wdata_c,
  input  logic              grp_clr,
  input  logic              step,
  input  logic              rl,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic              last,
  output logic              grp_end
);
  localparam logic [ADDR_W-1:0] ASTEP = ADDR_W'(STEP);
  localparam logic [CNT_W-1:0]  CONE  = CNT_W'(1);

  logic [ADDR_W-1:0] src_base, src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [GRP_W-1:0]  sub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      sub_q    <= '0;
    end else begin
      if (wr_src) begin
        src_base <= wdata_a;
        src_q    <= wdata_a;
      end else if (step) begin
        src_q <= (rl && grp_end) ? src_base : src_q + ASTEP;
      end
      if (wr_dst)    dst_q <= wdata_a;
      else if (step) dst_q <= dst_q - ASTEP;
      if (wr_cnt)    cnt_q <= wdata_c;
      else if (step) cnt_q <= cnt_q - CONE;
      if (grp_clr)   sub_q <= '0;
      else if (step) sub_q <= sub_q + 1'b1;
    end
  end

  assign src     = src_q;
  assign dst     = dst_q;
  assign last    = (cnt_q == CONE);
  assign grp_end = &sub_q;

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_cnt) |=> cnt_q == $past(cnt_q) - CONE);
  // R2
  dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_dst) |=> dst_q == $past(dst_q) - ASTEP);
  // R4
  src_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && rl && grp_end && !wr_src) |=> src_q == src_base);
endmodule

// File: rtl/dmarl_seq.sv
module dmarl_seq #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              rl,
  input  logic              dreq,
  input  logic              bgnt,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              last,
  input  logic              grp_end,
  output logic              breq,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [DATA_W-1:0] wdata,
  output logic              step,
  output logic              done_set,
  output logic              req_clr
);
  import dmarl_pkg::*;

  dmarl_st_e st_q, st_d;
  logic [DATA_W-1:0] data_q;
  logic clr_q;

  assign bus_valid = (st_q == ST_RD) || (st_q == ST_WR);
  assign bus_write = (st_q == ST_WR);
  assign breq      = (st_q != ST_IDLE);
  assign step      = (st_q == ST_WR) && bus_ready;
  assign done_set  = step && last;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (active && dreq) st_d = ST_REQ;
      ST_REQ:  if (bgnt) st_d = ST_RD;
      ST_RD:   if (bus_ready) st_d = ST_WR;
      ST_WR: begin
        if (bus_ready) begin
          if (last || (rl && grp_end)) st_d = ST_IDLE;
          else                         st_d = ST_RD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      clr_q <= done_set;
      if (st_q == ST_RD && bus_ready) data_q <= bus_rdata;
    end
  end

  assign wdata   = data_q;
  assign req_clr = clr_q;

  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> bus_valid && $stable(bus_write) && $stable(wdata));
  // R3
  end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> !breq && !bus_valid);
  // R3
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_clr |=> !req_clr);
  // R9
  wait_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REQ && !bgnt) |=> !bus_valid);
endmodule

// File: rtl/dmarl_top.sv
module dmarl_top #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int GRP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              dreq,
  output logic              breq,
  input  logic              bgnt,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              req_clr
);
  import dmarl_pkg::*;

  localparam int STEP = DATA_W / 8;

  logic active, rl, grp_clr, step, done_set, last, grp_end;
  logic [ADDR_W-1:0] src, dst;

  dmarl_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(reg_we && reg_sel == 2'(SEL_CTL)),
    .ctl_wdata(reg_wdata[3:0]),
    .done_set(done_set),
    .active(active), .rl(rl), .irq(irq), .grp_clr(grp_clr)
  );

  dmarl_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP), .GRP_W(GRP_W)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .wr_src(reg_we && reg_sel == 2'(SEL_SRC)),
    .wr_dst(reg_we && reg_sel == 2'(SEL_DST)),
    .wr_cnt(reg_we && reg_sel == 2'(SEL_CNT)),
    .wdata_a(reg_wdata[ADDR_W-1:0]),
    .wdata_c(reg_wdata[CNT_W-1:0]),
    .grp_clr(grp_clr), .step(step), .rl(rl),
    .src(src), .dst(dst), .last(last), .grp_end(grp_end)
  );

  dmarl_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .active(active), .rl(rl), .dreq(dreq), .bgnt(bgnt),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .last(last), .grp_end(grp_end),
    .breq(breq), .bus_valid(bus_valid), .bus_write(bus_write),
    .wdata(bus_wdata), .step(step), .done_set(done_set), .req_clr(req_clr)
  );

  assign bus_addr = bus_write ? dst : src;

  // R8
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> $stable(bus_addr));
endmodule

// File: tb/tb_dmarl_top.sv
`timescale 1ns/1ps
module tb_dmarl_top;
  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] cnt;
    logic        rl;
    logic        ie;
    logic [1:0]  rmode;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{32'h0400_0080, 32'h0040_0000, 16'd8,  1'b0, 1'b1, 2'd0},
    '{32'h0400_0080, 32'h0040_0000, 16'd8,  1'b1, 1'b1, 2'd1},
    '{32'h1000_0000, 32'h2000_0100, 16'd12, 1'b1, 1'b0, 2'd0},
    '{32'h0000_1000, 32'h0000_2000, 16'd5,  1'b0, 1'b1, 2'd2},
    '{32'h0000_0040, 32'h0000_0800, 16'd1,  1'b0, 1'b1, 2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic dreq = 1'b0, bgnt = 1'b0, bus_ready = 1'b0;
  logic breq, bus_valid, bus_write, irq, req_clr;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;

  dmarl_top dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dreq(dreq), .breq(breq), .bgnt(bgnt),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .req_clr(req_clr)
  );

  function automatic logic [31:0] mem_of(input logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'h5A5A_1234;
  endfunction

  assign bus_rdata = mem_of(bus_addr);

  int total = 0, bad = 0;
  int k = 0, rel_cnt = 0, clr_cnt = 0, cyc = 0, rd_cnt = 0;
  logic [31:0] e_src0 = '0, e_dst0 = '0;
  bit e_rl = 0, prev_breq = 0, pend = 0, mon_on = 0;
  logic [1:0] rmode = '0;
  logic [31:0] pend_addr = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_src(input int idx);
    return e_rl ? e_src0 + 32'(4 * (idx % 4)) : e_src0 + 32'(4 * idx);
  endfunction

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      logic rdy;
      if (prev_breq && !breq) rel_cnt++;
      prev_breq = breq;
      if (req_clr) clr_cnt++;
      if (bus_valid && !bgnt) chk(0, "R9 valid without grant", 32'(bus_valid), 32'(0));
      if (irq && clr_cnt == 0) chk(0, "R6 early irq", 32'(irq), 32'(0));
      if (pend) begin
        chk(bus_valid && bus_addr == pend_addr, "R8 held cycle", bus_addr, pend_addr);
        pend = 0;
      end
      case (rmode)
        2'd0:    rdy = 1'b1;
        2'd1:    rdy = cyc[0];
        default: rdy = (cyc % 3) != 0;
      endcase
      cyc++;
      bus_ready = rdy;
      if (bus_valid && !rdy) begin
        pend = 1;
        pend_addr = bus_addr;
      end
      if (bus_valid && rdy) begin
        if (!bus_write) begin
          chk(bus_addr == exp_src(k), "R2/R4 read address", bus_addr, exp_src(k));
          rd_cnt++;
        end else begin
          chk(bus_addr == e_dst0 - 32'(4 * k), "R2 write address", bus_addr, e_dst0 - 32'(4 * k));
          chk(bus_wdata == mem_of(exp_src(k)), "R2 write data", bus_wdata, mem_of(exp_src(k)));
          k++;
        end
      end
    end
    bgnt = breq;
  end

  task automatic wreg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic setup(input vec_t v);
    wreg(2'd3, 32'h0);
    wreg(2'd0, v.src);
    wreg(2'd1, v.dst);
    wreg(2'd2, {16'h0, v.cnt});
    e_src0 = v.src; e_dst0 = v.dst; e_rl = v.rl; rmode = v.rmode;
    k = 0; rel_cnt = 0; clr_cnt = 0; rd_cnt = 0; prev_breq = 0;
    mon_on = 1;
  endtask

  task automatic wait_clr();
    for (int i = 0; i < 5000 && clr_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 32'(0), 32'(1));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!breq && !bus_valid && !irq && !req_clr, "R1 reset outputs",
        {28'h0, breq, bus_valid, irq, req_clr}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      setup(VECS[i]);
      wreg(2'd3, {28'h0, 1'b0, VECS[i].ie, VECS[i].rl, 1'b1});
      dreq = 1'b1;
      wait_clr();
      dreq = 1'b0;
      chk(k == int'(VECS[i].cnt) && rd_cnt == int'(VECS[i].cnt), "R3 transfer count", 32'(k), 32'(VECS[i].cnt));
      chk(clr_cnt == 1, "R3 req_clr pulses", 32'(clr_cnt), 32'(1));
      chk(irq == VECS[i].ie, "R6 irq at end", 32'(irq), 32'(VECS[i].ie));
      chk(rel_cnt == (VECS[i].rl ? int'(VECS[i].cnt) / 4 : 1), "R5 bus releases",
          32'(rel_cnt), VECS[i].rl ? 32'(VECS[i].cnt / 4) : 32'(1));
    end

    // R5 pause at group boundary with dreq low, then resume from reloaded source
    setup('{32'h0000_3000, 32'h0000_9000, 16'd8, 1'b1, 1'b1, 2'd0});
    wreg(2'd3, 32'h7);
    dreq = 1'b1;
    for (int i = 0; i < 200 && !(k == 4 && !breq); i++) @(negedge clk);
    dreq = 1'b0;
    repeat (40) @(negedge clk);
    chk(k == 4 && !breq && !bus_valid, "R5 paused", {24'h0, 8'(k)}, 32'h4);
    chk(!irq, "R6 no irq at group boundary", 32'(irq), 32'(0));
    dreq = 1'b1;
    wait_clr();
    dreq = 1'b0;
    chk(k == 8 && irq, "R5 resumed to end", 32'(k), 32'(8));

    // R7 done flag blocks further requests
    dreq = 1'b1;
    repeat (20) @(negedge clk);
    chk(!breq, "R7 blocked after done", 32'(breq), 32'(0));
    wreg(2'd2, 32'd4);
    wreg(2'd3, 32'hF);
    repeat (20) @(negedge clk);
    chk(!breq && irq, "R7 done bit write 1 keeps flag", {30'h0, breq, irq}, 32'h1);
    // R10 reprogram and re-enable, group restarts on enable write
    dreq = 1'b0;
    setup('{32'h0000_5000, 32'h0000_6000, 16'd4, 1'b1, 1'b0, 2'd2});
    wreg(2'd3, 32'h3);
    chk(!irq, "R6 irq cleared with done", 32'(irq), 32'(0));
    dreq = 1'b1;
    wait_clr();
    dreq = 1'b0;
    chk(k == 4 && rel_cnt == 1 && !irq, "R10 re-enabled job", 32'(k), 32'(4));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule